// File: doc/BRIEF.md
# Loop Replay Fetch Buffer

This block sits between the instruction cache fetch path and the decoders. In normal operation it passes each aligned 16-byte fetch block through to a 32-byte decode port, one block per clock, with the upper half flagged empty. A loop hint gives the target and branch addresses of a taken backward branch. If the loop body covers no more than four aligned blocks, the buffer records those blocks as they next arrive from the cache. It then serves them to the decoders two at a time and in address order, without using the cache port, until a redirect leaves the loop.

The controller has four states. PASS forwards blocks and accepts hints. ARMED forwards blocks and waits for the target block. FILL forwards blocks and stores each consecutive block of the body. REPLAY drives the decode port from the store.

Its transitions are as follows:
- hint-accept moves PASS to ARMED.
- target-seen moves ARMED to FILL, or to REPLAY for a one-block loop.
- fill-done moves FILL to REPLAY.
- fill-break moves FILL back to ARMED.
- flush-out moves any state to PASS.
- flush-in keeps REPLAY and repositions the read pointer.

Top module: `loop_replay_buf`

## Requirements
- R1: After reset the block is in pass-through. With no fetch offered, do_valid is 0, do_hi_valid is 0 and fi_ready equals do_ready.
- R2: In pass-through, do_valid equals fi_valid, do_data[127:0] equals fi_data, do_addr is fi_addr with its low 4 bits cleared, do_hi_valid is 0, do_data[255:128] is 0, and fi_ready equals do_ready.
- R3: Hints are taken only in pass-through. A hint is taken only when the branch block (address bits [31:4]) is at or above the target block and the span (branch block − target block + 1) is 4 or less. Any other hint is ignored and the block stays in pass-through.
- R4: After a hint is taken, capture starts at the next accepted fetch of the target block. Capture then takes each following consecutive block. Replay starts in the cycle after the branch block is accepted.
- R5: In replay, fi_ready is 0 and do_valid is 1. do_addr is the address of the lower block, do_data[127:0] holds that block, and do_data[255:128] holds the next block when do_hi_valid is 1. The first output pair is the first two loop blocks, and each accepted pair advances two blocks.
- R6: In replay, the last block of a pass is presented alone when it has no partner, with do_hi_valid 0 and the upper half zero. The next output starts again at the first loop block. A one-block loop always presents that block alone.
- R7: In replay with do_ready low, do_addr, do_data and the read position do not change.
- R8: A flush to a block outside the captured loop (or any flush outside replay) clears the store. From the next cycle the block is in pass-through, and no replay occurs without a new hint.
- R9: A flush during replay to a block inside the loop keeps replay and restarts output at that block in the next cycle.
- R10: During capture, an accepted block that is not the next consecutive one abandons the capture. Capture restarts at the next arrival of the target block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fi_valid | input | 1 | Fetch block offered |
| fi_addr | input | 32 | Fetch block byte address |
| fi_data | input | 128 | Fetch block bytes |
| fi_ready | output | 1 | Fetch block accepted this cycle when high with fi_valid |
| hint_valid | input | 1 | Loop hint present |
| hint_tgt | input | 32 | Loop target byte address |
| hint_br | input | 32 | Loop branch byte address |
| flush_valid | input | 1 | Flush or redirect |
| flush_addr | input | 32 | Redirect byte address |
| do_valid | output | 1 | Decode output valid |
| do_addr | output | 32 | Byte address of the lower output block |
| do_data | output | 256 | Lower block in [127:0], upper block in [255:128] |
| do_hi_valid | output | 1 | Upper block present |
| do_ready | input | 1 | Decoder accepts output |

## Verification
Loops of one, three and four blocks are captured and replayed. Together they separate single-block passes, odd-length tails with wrap and full even pairing. Rejected hints (a five-block span and a backward span) show that capture depends on the span check. A fetch stream with a gap during capture separates restart-on-target from capturing whatever arrives. Stalls and in-loop redirects during replay tell pointer hold apart from pointer repositioning. Out-of-loop flushes confirm a clean return to pass-through.

// File: rtl/lrb_pkg.sv
package lrb_pkg;
    typedef enum logic [1:0] {
        ST_PASS,
        ST_ARMED,
        ST_FILL,
        ST_REPLAY
    } lrb_state_e;
endpackage

// File: rtl/lrb_hint_check.sv
module lrb_hint_check #(
    parameter int BAW   = 28,
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input  logic [BAW-1:0] tgt_blk,
    input  logic [BAW-1:0] br_blk,
    output logic           fits,
    output logic [CW-1:0]  span
);
    logic [BAW-1:0] diff;

    always_comb begin
        diff = br_blk - tgt_blk;
        fits = (br_blk >= tgt_blk) && (diff < BAW'(DEPTH));
        span = CW'(diff) + CW'(1);
    end
endmodule

// File: rtl/lrb_entry_store.sv
module lrb_entry_store #(
    parameter int DEPTH = 4,
    parameter int BW    = 128,
    parameter int IW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [BW-1:0]    wr_data,
    input  logic [IW-1:0]    rd_idx_a,
    input  logic [IW-1:0]    rd_idx_b,
    output logic [BW-1:0]    rd_a,
    output logic [BW-1:0]    rd_b,
    output logic [DEPTH-1:0] held
);
    logic [BW-1:0] slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                held[g] <= 1'b0;
                slot[g] <= '0;
            end else if (clr) begin
                held[g] <= 1'b0;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                held[g] <= 1'b1;
                slot[g] <= wr_data;
            end
        end
    end

    assign rd_a = slot[rd_idx_a];
    assign rd_b = slot[rd_idx_b];
endmodule

// File: rtl/loop_replay_buf.sv
module loop_replay_buf
    import lrb_pkg::*;
#(
    parameter int AW    = 32,
    parameter int BW    = 128,
    parameter int DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fi_valid,
    input  logic [AW-1:0]   fi_addr,
    input  logic [BW-1:0]   fi_data,
    output logic            fi_ready,
    input  logic            hint_valid,
    input  logic [AW-1:0]   hint_tgt,
    input  logic [AW-1:0]   hint_br,
    input  logic            flush_valid,
    input  logic [AW-1:0]   flush_addr,
    output logic            do_valid,
    output logic [AW-1:0]   do_addr,
    output logic [2*BW-1:0] do_data,
    output logic            do_hi_valid,
    input  logic            do_ready
);
    localparam int LSB = $clog2(BW / 8);
    localparam int BAW = AW - LSB;
    localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW  = $clog2(DEPTH + 1);

    lrb_state_e     st, st_nxt;
    logic [BAW-1:0] tgt_q, tgt_nxt;
    logic [CW-1:0]  cnt_q, cnt_nxt;
    logic [IW-1:0]  idx_q, idx_nxt;
    logic [IW-1:0]  rp_q, rp_nxt;

    logic [BAW-1:0] fi_blk, fl_blk, fl_off;
    logic           fl_in, accept, rp_last;
    logic           hint_fits;
    logic [CW-1:0]  hint_span;
    logic           st_clr, st_wr;
    logic [IW-1:0]  st_wr_idx, rd_b_idx;
    logic [BW-1:0]  rd_a, rd_b;
    logic [DEPTH-1:0] held;
    logic           unused_lo;

    assign unused_lo = ^{fi_addr[LSB-1:0], flush_addr[LSB-1:0],
                         hint_tgt[LSB-1:0], hint_br[LSB-1:0]};

    assign fi_blk  = fi_addr[AW-1:LSB];
    assign fl_blk  = flush_addr[AW-1:LSB];
    assign fl_off  = fl_blk - tgt_q;
    assign fl_in   = (fl_blk >= tgt_q) && (fl_off < BAW'(cnt_q));
    assign accept  = fi_valid && fi_ready;
    assign rp_last = (CW'(rp_q) == cnt_q - CW'(1));
    assign rd_b_idx = rp_last ? rp_q : rp_q + IW'(1);

    lrb_hint_check #(.BAW(BAW), .DEPTH(DEPTH), .CW(CW)) u_hint (
        .tgt_blk (hint_tgt[AW-1:LSB]),
        .br_blk  (hint_br[AW-1:LSB]),
        .fits    (hint_fits),
        .span    (hint_span)
    );

    lrb_entry_store #(.DEPTH(DEPTH), .BW(BW), .IW(IW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (st_clr),
        .wr_en    (st_wr),
        .wr_idx   (st_wr_idx),
        .wr_data  (fi_data),
        .rd_idx_a (rp_q),
        .rd_idx_b (rd_b_idx),
        .rd_a     (rd_a),
        .rd_b     (rd_b),
        .held     (held)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_PASS;
            tgt_q <= '0;
            cnt_q <= '0;
            idx_q <= '0;
            rp_q  <= '0;
        end else begin
            st    <= st_nxt;
            tgt_q <= tgt_nxt;
            cnt_q <= cnt_nxt;
            idx_q <= idx_nxt;
            rp_q  <= rp_nxt;
        end
    end

    // next state and store control
    always_comb begin
        st_nxt    = st;
        tgt_nxt   = tgt_q;
        cnt_nxt   = cnt_q;
        idx_nxt   = idx_q;
        rp_nxt    = rp_q;
        st_clr    = 1'b0;
        st_wr     = 1'b0;
        st_wr_idx = idx_q;
        if (flush_valid) begin
            if (st == ST_REPLAY && fl_in) begin
                rp_nxt = IW'(fl_off);
            end else begin
                st_nxt = ST_PASS;
                st_clr = 1'b1;
            end
        end else begin
            unique case (st)
                ST_PASS: begin
                    if (hint_valid && hint_fits) begin
                        st_nxt  = ST_ARMED;
                        tgt_nxt = hint_tgt[AW-1:LSB];
                        cnt_nxt = hint_span;
                        st_clr  = 1'b1;
                    end
                end
                ST_ARMED: begin
                    if (accept && fi_blk == tgt_q) begin
                        st_wr     = 1'b1;
                        st_wr_idx = '0;
                        idx_nxt   = IW'(1);
                        rp_nxt    = '0;
                        st_nxt    = (cnt_q == CW'(1)) ? ST_REPLAY : ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (accept) begin
                        if (fi_blk == tgt_q + BAW'(idx_q)) begin
                            st_wr   = 1'b1;
                            idx_nxt = idx_q + IW'(1);
                            if (CW'(idx_q) == cnt_q - CW'(1)) begin
                                st_nxt = ST_REPLAY;
                                rp_nxt = '0;
                            end
                        end else begin
                            st_nxt = ST_ARMED;
                            st_clr = 1'b1;
                        end
                    end
                end
                ST_REPLAY: begin
                    if (do_ready) begin
                        if (rp_last || (CW'(rp_q) + CW'(2) == cnt_q))
                            rp_nxt = '0;
                        else
                            rp_nxt = rp_q + IW'(2);
                    end
                end
                default: st_nxt = ST_PASS;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (st)
            ST_REPLAY: begin
                fi_ready    = 1'b0;
                do_valid    = 1'b1;
                do_addr     = {tgt_q + BAW'(rp_q), {LSB{1'b0}}};
                do_hi_valid = !rp_last;
                do_data     = {rp_last ? {BW{1'b0}} : rd_b, rd_a};
            end
            default: begin
                fi_ready    = do_ready;
                do_valid    = fi_valid;
                do_addr     = {fi_blk, {LSB{1'b0}}};
                do_hi_valid = 1'b0;
                do_data     = {{BW{1'b0}}, fi_data};
            end
        endcase
    end

    // a forwarding cycle never carries a second block
    assert_pass_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fi_ready |-> !do_hi_valid);

    // a paired output comes only from the store, with the cache port idle
    assert_pair_from_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
        do_hi_valid |-> (do_valid && !fi_ready));

    // replay only with the whole body held
    assert_store_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_REPLAY) |-> ($countones(held) == int'(cnt_q)));

    // stall keeps the output steady
    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_REPLAY && !do_ready && !flush_valid) |=>
        (st == ST_REPLAY && $stable(do_addr) && $stable(do_data)));
endmodule

// File: tb/loop_replay_buf_test.sv
module loop_replay_buf_test;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fi_valid = 1'b0;
    logic [31:0]  fi_addr = '0;
    logic [127:0] fi_data = '0;
    logic         fi_ready;
    logic         hint_valid = 1'b0;
    logic [31:0]  hint_tgt = '0;
    logic [31:0]  hint_br = '0;
    logic         flush_valid = 1'b0;
    logic [31:0]  flush_addr = '0;
    logic         do_valid;
    logic [31:0]  do_addr;
    logic [255:0] do_data;
    logic         do_hi_valid;
    logic         do_ready = 1'b1;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    loop_replay_buf uut (
        .clk(clk), .rst_n(rst_n),
        .fi_valid(fi_valid), .fi_addr(fi_addr), .fi_data(fi_data), .fi_ready(fi_ready),
        .hint_valid(hint_valid), .hint_tgt(hint_tgt), .hint_br(hint_br),
        .flush_valid(flush_valid), .flush_addr(flush_addr),
        .do_valid(do_valid), .do_addr(do_addr), .do_data(do_data),
        .do_hi_valid(do_hi_valid), .do_ready(do_ready)
    );

    function automatic logic [127:0] dat(input logic [27:0] b);
        return {4{4'hA, b}};
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [27:0] b);
        fi_valid = 1'b1;
        fi_addr  = {b, 4'h6};
        fi_data  = dat(b);
        @(negedge clk);
        check("R2 valid", 128'(do_valid), 128'(1));
        check("R2 addr", 128'(do_addr), 128'({b, 4'h0}));
        check("R2 data", do_data[127:0], dat(b));
        check("R2 upper", {do_data[255:128]} | 128'(do_hi_valid), 128'(0));
        check("R2 ready", 128'(fi_ready), 128'(do_ready));
        @(posedge clk); #1;
        fi_valid = 1'b0;
    endtask

    task automatic hint(input logic [27:0] t, input logic [27:0] br);
        hint_valid = 1'b1;
        hint_tgt   = {t, 4'h3};
        hint_br    = {br, 4'hE};
        @(posedge clk); #1;
        hint_valid = 1'b0;
    endtask

    task automatic flush(input logic [27:0] b);
        flush_valid = 1'b1;
        flush_addr  = {b, 4'h2};
        @(posedge clk); #1;
        flush_valid = 1'b0;
    endtask

    task automatic rstep(input string req, input logic [27:0] lo, input logic hiv);
        @(negedge clk);
        check({req, " valid"}, 128'({do_valid, fi_ready}), 128'(2'b10));
        check({req, " addr"}, 128'(do_addr), 128'({lo, 4'h0}));
        check({req, " lo"}, do_data[127:0], dat(lo));
        check({req, " hiv"}, 128'(do_hi_valid), 128'(hiv));
        check({req, " hi"}, do_data[255:128], hiv ? dat(lo + 28'd1) : 128'(0));
        @(posedge clk); #1;
    endtask

    task automatic expect_pass(input string req);
        @(negedge clk);
        check({req, " passthru"}, 128'({fi_ready, do_hi_valid}), 128'(2'b10));
        @(posedge clk); #1;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 valid", 128'(do_valid), 128'(0));
        check("R1 hi", 128'(do_hi_valid), 128'(0));
        check("R1 ready", 128'(fi_ready), 128'(1));
        @(posedge clk); #1;
    endtask

    task automatic t_pass;
        send(28'h200);
        send(28'h377);
    endtask

    task automatic t_loop3;
        hint(28'h100, 28'h102);
        send(28'h100); send(28'h101); send(28'h102);
        rstep("R5 first pair", 28'h100, 1'b1);
        rstep("R6 odd tail", 28'h102, 1'b0);
        rstep("R6 wrap", 28'h100, 1'b1);
        rstep("R6 tail again", 28'h102, 1'b0);
        flush(28'h050);
        expect_pass("R8 after flush");
        send(28'h100); send(28'h101); send(28'h102);
        expect_pass("R8 no replay");
    endtask

    task automatic t_loop4;
        hint(28'h300, 28'h303);
        send(28'h300); send(28'h301); send(28'h302); send(28'h303);
        rstep("R5 pair0", 28'h300, 1'b1);
        do_ready = 1'b0;
        @(negedge clk);
        check("R7 stall addr", 128'(do_addr), 128'({28'h302, 4'h0}));
        @(posedge clk); #1;
        @(negedge clk);
        check("R7 stall addr2", 128'(do_addr), 128'({28'h302, 4'h0}));
        check("R7 stall data", do_data[127:0], dat(28'h302));
        @(posedge clk); #1;
        do_ready = 1'b1;
        rstep("R7 resume", 28'h302, 1'b1);
        rstep("R5 pair wrap", 28'h300, 1'b1);
        flush(28'h301);
        rstep("R9 redirect", 28'h301, 1'b1);
        rstep("R9 tail", 28'h303, 1'b0);
        rstep("R9 wrap", 28'h300, 1'b1);
        flush(28'h304);
        expect_pass("R8 above loop");
    endtask

    task automatic t_loop1;
        hint(28'h400, 28'h400);
        send(28'h400);
        rstep("R6 single", 28'h400, 1'b0);
        rstep("R6 single again", 28'h400, 1'b0);
        flush(28'h3FF);
        expect_pass("R8 below loop");
    endtask

    task automatic t_reject;
        hint(28'h500, 28'h504);
        send(28'h500); send(28'h501); send(28'h502); send(28'h503); send(28'h504);
        expect_pass("R3 five blocks");
        hint(28'h600, 28'h5FF);
        send(28'h5FF); send(28'h600);
        expect_pass("R3 backward");
    endtask

    task automatic t_break;
        hint(28'h700, 28'h702);
        send(28'h700); send(28'h709); send(28'h701); send(28'h702);
        expect_pass("R10 gap abandons");
        send(28'h700); send(28'h701); send(28'h702);
        rstep("R10 recapture", 28'h700, 1'b1);
        rstep("R10 tail", 28'h702, 1'b0);
        flush(28'h000);
        expect_pass("R8 final");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_pass();
        t_loop3();
        t_loop4();
        t_loop1();
        t_reject();
        t_break();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule